// File: doc/BRIEF.md
# Tone-Pair Steering and Code Latch

This block sits behind a dual-tone detector. Each clock cycle the detector reports whether a valid tone pair is present, together with the pair's row index (low-group tone) and column index (high-group tone). The block decides whether a key press is genuine and when it has ended. Two programmable cycle counters take the place of an analog steering time constant. The presence counter requires the same pair to be reported for a minimum time. The absence counter requires the pair to be gone for a minimum time before the block releases.

When a pair qualifies, the block converts it to a 4-bit key code, stores the code in an output register and raises a delayed-steering flag. The flag stays high across short dropouts. Only after the absence time has run out does the flag fall, and only then can a new key be accepted.

Three further inputs shape the behaviour. An inhibit input blocks the fourth-column letter keys. An output enable either drives the code bus or leaves it at high impedance. A power-down input clears all qualification state but keeps the stored code.

Top module: `tone_steer_latch`

## Requirements
- R1: The key code is a function of row r and column c (each 0..3). For c in 0..2 and r in 0..2 the code is 3*r+c+1. Row 3 gives 1011, 1010 and 1100 for columns 0, 1 and 2. Column 3 gives 1101, 1110, 1111 and 0000 for rows 0, 1, 2 and 3.
- R2: A key is registered when `tone_valid` is sampled high with the same row and column at P+1 consecutive rising edges, where P is `present_cycles` and a value of 0 counts as 1. The code register and `steer_d` both update on that last edge.
- R3: After registration, `steer_d` stays high and nothing new is registered until `tone_valid` has been sampled low at A consecutive edges, where A is `absent_cycles` and 0 counts as 1. `steer_d` falls on that edge. A shorter dropout, or a different pair arriving while held, changes neither the code nor `steer_d`.
- R4: While `inhibit_letters` is high, a pair with column 3 never qualifies. It also breaks a qualification that is already in progress.
- R5: A change of row or column during qualification restarts the count from the new pair. An edge with `tone_valid` low also cancels the qualification in progress.
- R6: With `out_en` high, `code_out` carries the stored code. With `out_en` low, all four bits of `code_out` are high impedance.
- R7: Each edge that samples `pwr_down` high clears qualification and drives `steer_d` low. The stored code is kept through power-down.
- R8: After reset, the stored code is 0000 and `steer_d` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Active-high halt; clears detection state |
| inhibit_letters | input | 1 | Blocks column-3 keys when high |
| out_en | input | 1 | Drives code_out when high, high impedance when low |
| tone_valid | input | 1 | Detector reports a valid pair this cycle |
| row_idx | input | 2 | Low-group tone index |
| col_idx | input | 2 | High-group tone index |
| present_cycles | input | CNT_W | Presence guard time P |
| absent_cycles | input | CNT_W | Absence guard time A |
| code_out | output | 4 | Stored key code (tri-state) |
| steer_d | output | 1 | Delayed steering flag |

## Verification
Several internal faults show up at the ports on a predictable cycle:
- An off-by-one in the presence counter moves the rising edge of `steer_d` and the code update by one cycle at the P+1 boundary.
- A wrong absence count shows up either as a flag that drops during a short dropout or as a flag that falls one edge late.
- A candidate register that fails to restart on a pair change registers too early, or registers the wrong code.
- A letter that leaks past the inhibit input appears as a new code within P+1 cycles.
- Loss of the stored code in power-down is visible on `code_out` as soon as the output is enabled.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_QUAL = 2'd1, ST_HELD = 2'd2} steer_state_t;

  function automatic logic [3:0] key_code(input logic [1:0] r, input logic [1:0] c);
    logic [3:0] v;
    if (c == 2'd3) v = (r == 2'd3) ? 4'd0 : 4'(4'd13 + {2'b00, r});
    else if (r == 2'd3) v = (c == 2'd0) ? 4'd11 : (c == 2'd1) ? 4'd10 : 4'd12;
    else v = 4'({2'b00, r} * 4'd3 + {2'b00, c} + 4'd1);
    return v;
  endfunction

  function automatic logic is_letter(input logic [1:0] c);
    return c == 2'd3;
  endfunction
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import tone_steer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             inhibit_letters,
  input  logic             tone_valid,
  input  logic [3:0]       key_in,
  input  logic [CNT_W-1:0] present_cycles,
  input  logic [CNT_W-1:0] absent_cycles,
  output logic             load_evt,
  output logic             release_evt,
  output logic             held
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  steer_state_t   st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]     cand;
  logic [CNT_W:0] p_lim, a_lim, cnt_nx;
  logic           allowed, same_key;

  assign p_lim    = (present_cycles == '0) ? ONE : {1'b0, present_cycles};
  assign a_lim    = (absent_cycles  == '0) ? ONE : {1'b0, absent_cycles};
  assign cnt_nx   = {1'b0, cnt} + ONE;
  assign allowed  = tone_valid && !(inhibit_letters && is_letter(key_in[1:0]));
  assign same_key = (key_in == cand);

  assign load_evt    = (st == ST_QUAL) && allowed && same_key && ({1'b0, cnt} >= p_lim);
  assign release_evt = (st == ST_HELD) && !tone_valid && (cnt_nx >= a_lim);
  assign held        = (st == ST_HELD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; cand <= '0;
    end else if (pwr_down) begin
      st <= ST_IDLE; cnt <= '0; cand <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (allowed) begin
          st <= ST_QUAL; cnt <= CNT_W'(1); cand <= key_in;
        end
        ST_QUAL: begin
          if (load_evt) begin
            st <= ST_HELD; cnt <= '0;
          end else if (allowed && same_key) begin
            cnt <= cnt_nx[CNT_W-1:0];
          end else if (allowed) begin
            cnt <= CNT_W'(1); cand <= key_in;
          end else begin
            st <= ST_IDLE; cnt <= '0;
          end
        end
        ST_HELD: begin
          if (tone_valid) cnt <= '0;
          else if (release_evt) begin
            st <= ST_IDLE; cnt <= '0;
          end else cnt <= cnt_nx[CNT_W-1:0];
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_NO_LOAD_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !load_evt); // R3
  AST_INHIBIT_LETTER: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && inhibit_letters) |-> !is_letter(key_in[1:0])); // R4
  AST_LOAD_SETS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !pwr_down) |=> held); // R2
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt || pwr_down) |=> !held); // R3
endmodule

// File: rtl/code_latch.sv
module code_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [3:0] code_in,
  output logic [3:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= 4'd0;
    else if (load) code_q <= code_in;
  end

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code_q)); // R7
endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch
  import tone_steer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             inhibit_letters,
  input  logic             out_en,
  input  logic             tone_valid,
  input  logic [1:0]       row_idx,
  input  logic [1:0]       col_idx,
  input  logic [CNT_W-1:0] present_cycles,
  input  logic [CNT_W-1:0] absent_cycles,
  output logic [3:0]       code_out,
  output logic             steer_d
);
  logic       load_evt, release_evt, held;
  logic [3:0] code_q;

  steer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .inhibit_letters(inhibit_letters),
    .tone_valid(tone_valid), .key_in({row_idx, col_idx}),
    .present_cycles(present_cycles), .absent_cycles(absent_cycles),
    .load_evt(load_evt), .release_evt(release_evt), .held(held)
  );

  code_latch u_latch (
    .clk(clk), .rst_n(rst_n), .load(load_evt && !pwr_down),
    .code_in(key_code(row_idx, col_idx)), .code_q(code_q)
  );

  assign steer_d  = held;
  assign code_out = out_en ? code_q : 4'bzzzz;

  AST_PWDN_STEER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !steer_d); // R7
  AST_STEER_RISE_NEW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_d) |-> code_q == key_code($past(row_idx), $past(col_idx))); // R1
endmodule

// File: tb/tone_steer_latch_bench.sv
module tone_steer_latch_bench;
  localparam int CNT_W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_down = 0, inhibit_letters = 0, out_en = 1, tone_valid = 0;
  logic [1:0] row_idx = 0, col_idx = 0;
  logic [CNT_W-1:0] present_cycles = 8'd4, absent_cycles = 8'd3;
  logic [3:0] code_out;
  logic steer_d;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  tone_steer_latch #(.CNT_W(CNT_W)) u_tone_steer_latch (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .inhibit_letters(inhibit_letters),
    .out_en(out_en), .tone_valid(tone_valid), .row_idx(row_idx), .col_idx(col_idx),
    .present_cycles(present_cycles), .absent_cycles(absent_cycles),
    .code_out(code_out), .steer_d(steer_d));

  always #5 clk = ~clk;

  // bench-side reference state
  bit m_busy = 0;
  int m_run = 0, m_gap = 0;
  logic [3:0] m_code = 0, m_key = 0;
  string cur_req = "R2 R3";

  function automatic logic [3:0] ref_code(input logic [1:0] r, input logic [1:0] c);
    case ({r, c})
      4'h0: return 4'h1; 4'h1: return 4'h2; 4'h2: return 4'h3; 4'h3: return 4'hD;
      4'h4: return 4'h4; 4'h5: return 4'h5; 4'h6: return 4'h6; 4'h7: return 4'hE;
      4'h8: return 4'h7; 4'h9: return 4'h8; 4'hA: return 4'h9; 4'hB: return 4'hF;
      4'hC: return 4'hB; 4'hD: return 4'hA; 4'hE: return 4'hC; default: return 4'h0;
    endcase
  endfunction

  function automatic int eff(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit ok;
    logic [3:0] k;
    k  = {row_idx, col_idx};
    ok = tone_valid && !(inhibit_letters && col_idx == 2'd3);
    if (pwr_down) begin
      m_busy = 0; m_run = 0; m_gap = 0;
    end else if (!m_busy) begin
      if (ok && m_run > 0 && k == m_key) m_run++;
      else if (ok) begin m_run = 1; m_key = k; end
      else m_run = 0;
      if (m_run >= eff(present_cycles) + 1) begin
        m_busy = 1; m_code = ref_code(row_idx, col_idx); m_gap = 0; m_run = 0;
      end
    end else begin
      if (tone_valid) m_gap = 0;
      else begin
        m_gap++;
        if (m_gap >= eff(absent_cycles)) begin m_busy = 0; m_run = 0; end
      end
    end
  endtask

  task automatic tick(input bit v, input logic [1:0] r, input logic [1:0] c);
    @(negedge clk);
    tone_valid = v; row_idx = r; col_idx = c;
    @(posedge clk);
    model_edge();
    #1;
    chk({cur_req, " steer"}, {3'b0, steer_d}, {3'b0, m_busy});
    if (out_en) chk({cur_req, " code"}, code_out, m_code);
    else chk("R6 hi-z", code_out, 4'bzzzz);
  endtask

  task automatic press(input logic [1:0] r, input logic [1:0] c, input int n);
    for (int i = 0; i < n; i++) tick(1, r, c);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) tick(0, row_idx, col_idx);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    #1;
    chk("R8 reset steer", {3'b0, steer_d}, 4'd0);
    chk("R8 reset code", code_out, 4'd0);

    // R1 R2: every key, registered exactly on the P+1th edge
    cur_req = "R1 R2";
    for (int k = 0; k < 16; k++) begin
      press(2'(k >> 2), 2'(k), 4);
      chk("R2 not before P+1", {3'b0, steer_d}, 4'd0);
      press(2'(k >> 2), 2'(k), 1);
      chk("R2 steer at P+1", {3'b0, steer_d}, 4'd1);
      chk("R1 code", code_out, ref_code(2'(k >> 2), 2'(k)));
      gap(3);
      chk("R3 release after A", {3'b0, steer_d}, 4'd0);
    end

    // R3: short dropout and new pair while held
    cur_req = "R3";
    press(0, 0, 5);
    gap(2);
    press(1, 1, 10);
    chk("R3 held through dropout", {3'b0, steer_d}, 4'd1);
    chk("R3 code unchanged", code_out, 4'h1);
    gap(2);
    chk("R3 one edge before release", {3'b0, steer_d}, 4'd1);
    gap(1);
    chk("R3 falls on Ath edge", {3'b0, steer_d}, 4'd0);

    // R4: inhibit blocks column-3 keys
    cur_req = "R4";
    inhibit_letters = 1;
    press(1, 3, 12);
    chk("R4 letter blocked steer", {3'b0, steer_d}, 4'd0);
    chk("R4 letter blocked code", code_out, 4'h1);
    press(2, 2, 5);
    chk("R4 digit allowed", code_out, 4'h9);
    gap(3);
    inhibit_letters = 0;
    press(2, 3, 3);
    inhibit_letters = 1;
    press(2, 3, 3);
    inhibit_letters = 0;
    chk("R4 breaks ongoing qual", {3'b0, steer_d}, 4'd0);
    gap(2);

    // R5: key change restarts count
    cur_req = "R5";
    press(0, 1, 3);
    press(3, 1, 3);
    chk("R5 restart no reg", {3'b0, steer_d}, 4'd0);
    press(3, 1, 2);
    chk("R5 reg after restart", code_out, 4'hA);
    gap(3);
    press(3, 2, 3); gap(1); press(3, 2, 4);
    chk("R5 dropout cancels", {3'b0, steer_d}, 4'd0);
    press(3, 2, 1);
    chk("R5 reg after fresh run", code_out, 4'hC);
    gap(3);

    // R6: output enable
    out_en = 0;
    press(0, 2, 5);
    out_en = 1;
    #1 chk("R6 driven again", code_out, 4'h3);
    gap(3);

    // R7: power-down keeps the code, clears steering
    cur_req = "R7";
    press(1, 0, 5);
    pwr_down = 1;
    press(1, 0, 8);
    chk("R7 steer low", {3'b0, steer_d}, 4'd0);
    chk("R7 code held", code_out, 4'h4);
    pwr_down = 0;
    press(1, 0, 4);
    chk("R7 requalify needed", {3'b0, steer_d}, 4'd0);
    press(1, 0, 1);
    chk("R7 requalified", {3'b0, steer_d}, 4'd1);
    gap(3);

    // R2 R3: zero guard values behave as 1
    present_cycles = 0; absent_cycles = 0;
    press(2, 1, 1);
    chk("R2 P=0 not yet", {3'b0, steer_d}, 4'd0);
    press(2, 1, 1);
    chk("R2 P=0 as 1", code_out, 4'h8);
    gap(1);
    chk("R3 A=0 as 1", {3'b0, steer_d}, 4'd0);

    // random mix against the reference
    cur_req = "R1 R2 R3 R4 R5 R7";
    void'($urandom(32'hC0FFEE));
    present_cycles = 8'd3; absent_cycles = 8'd2;
    for (int s = 0; s < 400; s++) begin
      logic [1:0] r, c;
      r = 2'($urandom); c = 2'($urandom);
      inhibit_letters = ($urandom % 4) == 0;
      pwr_down = ($urandom % 20) == 0;
      out_en = ($urandom % 8) != 0;
      if ((s % 100) == 50) begin
        pwr_down = 1;
        present_cycles = 8'($urandom % 6);
        absent_cycles = 8'($urandom % 5);
      end
      press(r, c, 1 + int'($urandom % 8));
      if ($urandom % 3 == 0) press(2'($urandom), c, 1 + int'($urandom % 3));
      pwr_down = 0;
      gap(int'($urandom % 5));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1;
    $finish;
  end
endmodule